// File: doc/BRIEF.md
# Conversion Result Buffer with Interrupt Pacing

This block holds the words produced by an analog-to-digital conversion sequencer and tells the processor when a batch is ready. Each write strobe from the sequencer marks one completed sample/convert sequence and stores one result. The block raises its interrupt flag only after a programmed number of sequences, so software handles results in batches rather than one at a time.

The storage has two layouts. In linear layout it is one 16-entry ring. In ping-pong layout it is two 8-entry halves. The hardware fills one half while software reads the other, and a status output shows which half is being written. Software reads any entry through an indexed port, and clears the sticky flag with a one-cycle strobe. Wake-up decisions, priority comparison and result formatting are handled elsewhere.

The fill sequencer is a three-state machine:

| State | Meaning |
|---|---|
| `FILL_WHOLE` | Linear layout. |
| `FILL_LOWER` | Ping-pong layout, filling entries 0–7. |
| `FILL_UPPER` | Ping-pong layout, filling entries 8–15. |

Its transitions are:

| Transition | From → To | Condition |
|---|---|---|
| batch-end | `FILL_LOWER` → `FILL_UPPER` | The batch of N+1 sequences completes. |
| batch-end | `FILL_UPPER` → `FILL_LOWER` | The batch of N+1 sequences completes. |
| batch-end | `FILL_WHOLE` → `FILL_WHOLE` | The batch of N+1 sequences completes. |
| reconfigure | any → `FILL_LOWER` or `FILL_WHOLE` | The layout bit or interval field differs from its value in the previous cycle. The target depends on the new layout bit. |

Top module: `adc_result_pacer`

## Requirements
- R1: With `split_mode_i`=0, successive writes go to entries 0, 1, 2 and so on of the 16-entry store. The pointer wraps from 15 to 0.
- R2: With `split_mode_i`=1, writes stay in one 8-entry half. After a reconfigure, filling starts in the lower half (entries 0–7). The write offset wraps within the half (7 to 0).
- R3: `fill_upper_o` is 1 exactly while the upper half (entries 8–15) is being filled in ping-pong layout. It is 0 in linear layout and while the lower half is being filled.
- R4: With interval field N (0–15), the batch-end event occurs on the (N+1)-th write after the last batch-end or reconfigure. If `irq_en_i`=1, `irq_o` is 1 from the next cycle.
- R5: After each batch-end, the next write goes to the start of the active region (entry 0 in linear layout). In ping-pong layout, the next write goes to offset 0 of the other half.
- R6: `irq_o` stays 1 until a cycle with `irq_clr_i`=1; it is 0 after that cycle. When a clear and a batch-end with enable fall in the same cycle, the flag ends up 1.
- R7: While `irq_en_i`=0, a batch-end does not set `irq_o`. The pointer reset and the half switch still happen.
- R8: A change of `split_mode_i` or `interval_i` resets the write offset, the sequence count and the half selection (to lower). A write in the cycle of the change uses the new settings, goes to entry 0, and counts as the first sequence of the batch.
- R9: `rd_data_o` returns the 12-bit word last stored at entry `rd_idx_i`, combinationally, in bits 11:0. Bits 15:12 read 0.
- R10: After reset, `irq_o` and `fill_upper_o` are 0. The first write goes to entry 0. Buffer contents are not defined by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Write strobe: one completed sequence result |
| res_data_i | input | 12 | Result word |
| split_mode_i | input | 1 | 0 = one 16-entry buffer, 1 = two 8-entry halves |
| interval_i | input | 4 | N: interrupt after every N+1 sequences |
| irq_en_i | input | 1 | Allows batch-end to set the flag |
| irq_clr_i | input | 1 | Clears the sticky flag |
| rd_idx_i | input | 4 | Entry number to read |
| rd_data_o | output | 16 | Read data, upper bits zero |
| fill_upper_o | output | 1 | Upper half being filled (ping-pong layout only) |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps both layouts against every interval value from 0 to 15, and predicts entry addresses and flag timing from the write count alone. This catches an off-by-one batch length, which would raise the flag one write early or late. It also catches a pointer that is not rewound at batch-end, which would leave results scattered past the batch start or in the wrong half. Further checks aim at these cases:

- Intervals longer than a half: a design that wrapped wrongly would spill into the other half.
- A write landing in the same cycle as a reconfigure: it would be placed at the old pointer or miscounted.
- A clear that collides with a new event: the event would be lost.
- A disabled interrupt that also froze the half switch.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

    typedef enum logic [1:0] {
        FILL_WHOLE = 2'd0,
        FILL_LOWER = 2'd1,
        FILL_UPPER = 2'd2
    } fill_state_e;

endpackage

// File: rtl/rb_fill_fsm.sv
module rb_fill_fsm
    import adc_rb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_i,
    input  logic                     split_i,
    input  logic [CNT_W-1:0]         interval_i,
    output logic [$clog2(DEPTH)-1:0] wr_addr_o,
    output logic                     seq_evt_o,
    output logic                     upper_o
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int HALF_W = IDX_W - 1;

    fill_state_e      state_q, state_d, cur_state;
    logic [IDX_W-1:0] off_q, off_d, cur_off;
    logic [CNT_W-1:0] cnt_q, cnt_d, cur_cnt;
    logic             split_q;
    logic [CNT_W-1:0] intv_q;
    logic             cfg_chg;
    logic             seq_last;

    // State register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FILL_WHOLE;
            off_q   <= '0;
            cnt_q   <= '0;
            split_q <= 1'b0;
            intv_q  <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
            cnt_q   <= cnt_d;
            split_q <= split_i;
            intv_q  <= interval_i;
        end
    end

    // Effective state: a reconfigure takes effect in the same cycle
    always_comb begin
        cfg_chg   = (split_i != split_q) || (interval_i != intv_q);
        cur_state = state_q;
        cur_off   = off_q;
        cur_cnt   = cnt_q;
        if (cfg_chg) begin
            cur_state = split_i ? FILL_LOWER : FILL_WHOLE;
            cur_off   = '0;
            cur_cnt   = '0;
        end
    end

    // Next-state process
    always_comb begin
        seq_last = wr_i && (cur_cnt == interval_i);
        state_d  = cur_state;
        off_d    = cur_off;
        cnt_d    = cur_cnt;
        if (wr_i) begin
            if (seq_last) begin
                off_d = '0;
                cnt_d = '0;
                unique case (cur_state)
                    FILL_WHOLE: state_d = FILL_WHOLE;
                    FILL_LOWER: state_d = FILL_UPPER;
                    FILL_UPPER: state_d = FILL_LOWER;
                    default:    state_d = FILL_WHOLE;
                endcase
            end else begin
                cnt_d = cur_cnt + 1'b1;
                if (cur_state == FILL_WHOLE) begin
                    off_d = cur_off + 1'b1;
                end else begin
                    off_d = {1'b0, cur_off[HALF_W-1:0] + 1'b1};
                end
            end
        end
    end

    // Output process
    always_comb begin
        unique case (cur_state)
            FILL_WHOLE: wr_addr_o = cur_off;
            FILL_LOWER: wr_addr_o = {1'b0, cur_off[HALF_W-1:0]};
            FILL_UPPER: wr_addr_o = {1'b1, cur_off[HALF_W-1:0]};
            default:    wr_addr_o = cur_off;
        endcase
        seq_evt_o = seq_last;
        upper_o   = (state_q == FILL_UPPER);
    end

endmodule

// File: rtl/rb_storage.sv
module rb_storage #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 12,
    parameter int BUS_W  = 16
) (
    input  logic                     clk_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [BUS_W-1:0]         rd_data_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_word;

    // Contents deliberately carry no reset
    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_word = mem_q[rd_idx_i];

    generate
        if (BUS_W > DATA_W) begin : g_pad
            assign rd_data_o = {{(BUS_W - DATA_W){1'b0}}, rd_word};
        end else begin : g_trunc
            assign rd_data_o = rd_word[BUS_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rb_irq_flag.sv
module rb_irq_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // A new enabled event outranks a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (evt_i && en_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/adc_result_pacer.sv
module adc_result_pacer #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 12,
    parameter int BUS_W  = 16,
    parameter int CNT_W  = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     res_valid_i,
    input  logic [DATA_W-1:0]        res_data_i,
    input  logic                     split_mode_i,
    input  logic [CNT_W-1:0]         interval_i,
    input  logic                     irq_en_i,
    input  logic                     irq_clr_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [BUS_W-1:0]         rd_data_o,
    output logic                     fill_upper_o,
    output logic                     irq_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] wr_addr;
    logic             seq_evt;

    rb_fill_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (res_valid_i),
        .split_i    (split_mode_i),
        .interval_i (interval_i),
        .wr_addr_o  (wr_addr),
        .seq_evt_o  (seq_evt),
        .upper_o    (fill_upper_o)
    );

    rb_storage #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .BUS_W  (BUS_W)
    ) store_i (
        .clk_i     (clk_i),
        .wr_en_i   (res_valid_i),
        .wr_addr_i (wr_addr),
        .wr_data_i (res_data_i),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );

    rb_irq_flag flag_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (seq_evt),
        .en_i   (irq_en_i),
        .clr_i  (irq_clr_i),
        .flag_o (irq_o)
    );

endmodule

// File: rtl/rb_pacer_checker.sv
module rb_pacer_checker #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             res_valid_i,
    input logic             split_mode_i,
    input logic [CNT_W-1:0] interval_i,
    input logic             irq_en_i,
    input logic             irq_clr_i,
    input logic             irq_o,
    input logic             fill_upper_o,
    input logic [IDX_W-1:0] wr_addr,
    input logic             seq_evt
);

    assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !irq_clr_i |=> irq_o);

    assert_flag_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && irq_clr_i && !(seq_evt && irq_en_i) |=> !irq_o);

    assert_no_set_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o && !irq_en_i |=> !irq_o);

    assert_rise_on_batch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_evt && irq_en_i |=> irq_o);

    assert_linear_no_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !split_mode_i |=> !fill_upper_o);

    assert_rewind_after_batch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_evt |=> (wr_addr[IDX_W-2:0] == '0));

    assert_linear_advance_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_i && !seq_evt && !split_mode_i |=>
            ((split_mode_i != $past(split_mode_i)) || (interval_i != $past(interval_i))
             || (wr_addr == IDX_W'($past(wr_addr) + 1'b1))));

endmodule

bind adc_result_pacer rb_pacer_checker #(
    .IDX_W ($clog2(DEPTH)),
    .CNT_W (CNT_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .res_valid_i  (res_valid_i),
    .split_mode_i (split_mode_i),
    .interval_i   (interval_i),
    .irq_en_i     (irq_en_i),
    .irq_clr_i    (irq_clr_i),
    .irq_o        (irq_o),
    .fill_upper_o (fill_upper_o),
    .wr_addr      (wr_addr),
    .seq_evt      (seq_evt)
);

// File: tb/adc_result_pacer_tb_top.sv
module adc_result_pacer_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        res_valid_i = 1'b0;
    logic [11:0] res_data_i = '0;
    logic        split_mode_i = 1'b0;
    logic [3:0]  interval_i = '0;
    logic        irq_en_i = 1'b1;
    logic        irq_clr_i = 1'b0;
    logic [3:0]  rd_idx_i = '0;
    logic [15:0] rd_data_o;
    logic        fill_upper_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] exp_mem [16];
    bit          exp_vld [16];

    always #4 clk_i = ~clk_i;

    adc_result_pacer dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .res_valid_i  (res_valid_i),
        .res_data_i   (res_data_i),
        .split_mode_i (split_mode_i),
        .interval_i   (interval_i),
        .irq_en_i     (irq_en_i),
        .irq_clr_i    (irq_clr_i),
        .rd_idx_i     (rd_idx_i),
        .rd_data_o    (rd_data_o),
        .fill_upper_o (fill_upper_o),
        .irq_o        (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: inputs applied at negedge, outputs settled at next negedge
    task automatic cyc(input logic wr, input logic [11:0] d, input logic clr);
        res_valid_i = wr;
        res_data_i  = d;
        irq_clr_i   = clr;
        @(posedge clk_i);
        @(negedge clk_i);
        res_valid_i = 1'b0;
        irq_clr_i   = 1'b0;
    endtask

    task automatic set_cfg(input logic sp, input logic [3:0] n);
        split_mode_i = sp;
        interval_i   = n;
        cyc(1'b0, 12'h0, 1'b0);
        cyc(1'b0, 12'h0, 1'b1);
        for (int k = 0; k < 16; k++) exp_vld[k] = 1'b0;
    endtask

    task automatic read_back(input string req);
        for (int k = 0; k < 16; k++) begin
            if (exp_vld[k]) begin
                rd_idx_i = 4'(k);
                #1;
                check(req, {16'h0, rd_data_o}, {20'h0, exp_mem[k]});
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R10 irq after reset", {31'h0, irq_o}, 32'h0);
        check("R10 upper after reset", {31'h0, fill_upper_o}, 32'h0);

        // Sweep both layouts across every interval value
        for (int sp = 0; sp < 2; sp++) begin
            for (int n = 0; n < 16; n++) begin
                int p;
                int nw;
                p  = n + 1;
                nw = 2 * p + 3;
                set_cfg(sp[0], 4'(n));
                for (int j = 0; j < nw; j++) begin
                    int a;
                    logic [11:0] d;
                    d = 12'((sp * 16 + n) * 64 + j);
                    if (sp == 0) a = (j % p) % 16;
                    else a = ((j / p) % 2) * 8 + (j % p) % 8;
                    exp_mem[a] = d;
                    exp_vld[a] = 1'b1;
                    cyc(1'b1, d, 1'b0);
                    check("R4 flag after write", {31'h0, irq_o}, {31'h0, (j + 1 >= p)});
                    if (sp == 0)
                        check("R3 upper in linear", {31'h0, fill_upper_o}, 32'h0);
                    else
                        check("R3 R5 half select", {31'h0, fill_upper_o},
                              32'(((j + 1) / p) % 2));
                end
                if (sp == 0) read_back("R1 R9 linear entry");
                else read_back("R2 R5 R9 split entry");
            end
        end

        // R8: reconfigure in the middle of a batch, with a write in that cycle
        set_cfg(1'b1, 4'd3);
        for (int j = 0; j < 5; j++) cyc(1'b1, 12'(12'h100 + j), 1'b0);
        check("R5 switched to upper", {31'h0, fill_upper_o}, 32'h1);
        interval_i = 4'd4;
        cyc(1'b1, 12'hABC, 1'b0);
        check("R8 half reset to lower", {31'h0, fill_upper_o}, 32'h0);
        rd_idx_i = 4'd0;
        #1;
        check("R8 write in change cycle at entry 0", {16'h0, rd_data_o}, 32'hABC);
        cyc(1'b0, 12'h0, 1'b1);
        for (int j = 0; j < 3; j++) cyc(1'b1, 12'(12'h200 + j), 1'b0);
        check("R8 count restarted, no flag yet", {31'h0, irq_o}, 32'h0);
        cyc(1'b1, 12'h2FF, 1'b0);
        check("R8 flag on fifth write", {31'h0, irq_o}, 32'h1);
        rd_idx_i = 4'd4;
        #1;
        check("R8 fifth write at entry 4", {16'h0, rd_data_o}, 32'h2FF);

        // R7: disabled interrupt still switches halves
        irq_en_i = 1'b0;
        set_cfg(1'b1, 4'd2);
        for (int j = 0; j < 3; j++) cyc(1'b1, 12'(12'h300 + j), 1'b0);
        check("R7 no flag when disabled", {31'h0, irq_o}, 32'h0);
        check("R7 half still switches", {31'h0, fill_upper_o}, 32'h1);
        irq_en_i = 1'b1;
        for (int j = 0; j < 3; j++) cyc(1'b1, 12'(12'h310 + j), 1'b0);
        check("R7 flag once enabled", {31'h0, irq_o}, 32'h1);
        check("R5 back to lower", {31'h0, fill_upper_o}, 32'h0);

        // R6: stickiness and clear/set collision
        set_cfg(1'b0, 4'd0);
        check("R6 cleared", {31'h0, irq_o}, 32'h0);
        cyc(1'b1, 12'h055, 1'b1);
        check("R6 set wins over clear", {31'h0, irq_o}, 32'h1);
        for (int j = 0; j < 3; j++) cyc(1'b0, 12'h0, 1'b0);
        check("R6 flag sticky", {31'h0, irq_o}, 32'h1);
        cyc(1'b0, 12'h0, 1'b1);
        check("R6 clear strobe", {31'h0, irq_o}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule